// File: doc/BRIEF.md
# Byte-Wide Read-Only Memory Emulator with Access Timing

This block stands in for a byte-wide, erasable or one-time-programmable read-only memory. It can sit at the far end of a memory-interface testbench, or replace the physical part in a prototype. It samples all of its pins on a clock. It decodes four modes from two active-low enables and a flag that marks a raised voltage on an address pin:

- **Array read**: returns stored bytes.
- **Identifier read**: returns two fixed identifier bytes.
- **Output disable**: the data pins are released.
- **Standby**: the data pins are released.

Access timing is expressed in clock cycles. Three separate counters track the time since the address changed, since chip enable fell and since output enable fell. Data is flagged valid only once every counter has run out. A fourth counter keeps the data pins driven, holding an invalid value, for a set number of cycles after the part is deselected. The stored content is written from a computed pattern during reset, and there is no write port. The pins carry no flow of transfers, so there is no valid/ready handshake and no back-pressure: the host simply waits for `q_valid`.

The full 19-bit address space is kept. Only the low `STORE_AW` bits index the stored array, and the higher bits mirror it.

Top module: `eprom_emu`

## Requirements
- R1: While reset is held and directly after it, `q_oe` is 0, `q_valid` is 0 and `q` is 00h.
- R2: `q_valid` is 1 only when `q_oe` is 1, and only while both `ce_n` and `oe_n` were sampled low at the last edge.
- R3: With `ce_n` high (standby), `q_oe` is 0 from `T_FLOAT` cycles after deselection onward, whatever the level of `oe_n`.
- R4: With `ce_n` low and `oe_n` high (output disable), `q_oe` is 0 from `T_FLOAT` cycles after deselection onward.
- R5: With `hv_sig` high and both enables low, a valid `q` is 20h when `addr[0]` is 0 and 41h when `addr[0]` is 1. All other address bits are ignored.
- R6: In array read, a valid `q` equals `(idx*37 + 5Ah) mod 256`, where idx is `addr[STORE_AW-1:0]`. Higher address bits do not change the result.
- R7: A change of `addr` or `hv_sig` sampled at edge E clears `q_valid` from E, with zero hold. `q_valid` returns no earlier than edge E+`T_ADDR`.
- R8: A falling `ce_n` sampled at edge E keeps `q_valid` low until edge E+`T_CE`.
- R9: A falling `oe_n` sampled at edge E keeps `q_valid` low until edge E+`T_OE`. When several of these events fall at the same edge, the longest delay governs.
- R10: When either enable is sampled high at edge X after a selected state, `q_oe` stays 1 with `q_valid` 0 through edge X+`T_FLOAT`-1. `q_oe` falls at edge X+`T_FLOAT`.
- R11: `q` is 00h whenever `q_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; also loads the stored pattern |
| addr | input | ADDR_W (19) | Byte address |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| hv_sig | input | 1 | Marks a raised voltage on address pin 9 (identifier read) |
| q | output | DATA_W (8) | Data out, 00h while not valid |
| q_oe | output | 1 | Data pins driven (0 = high impedance) |
| q_valid | output | 1 | Data on `q` has met all access delays |

## Verification
The bench sweeps every stored index, each with a different pattern on the upper address bits. It checks that each byte becomes valid exactly one cycle past the address delay and not before. A design with an off-by-one latency, or with aliasing that ignored mirroring, would show the wrong byte or a valid flag one cycle early.

The identifier codes are checked under several upper-address patterns. A design that leaked array data into identifier read, or swapped the two codes, fails there.

Separate scenarios isolate the chip-enable delay, the output-enable delay, and simultaneous events, where the longest delay must govern. They also cover the float window after deselection by either enable. A design that released the pins at once, or kept them driven in standby, would show the wrong `q_oe` in those windows.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUTDIS  = 2'd1,
    MODE_ARRAY   = 2'd2,
    MODE_IDENT   = 2'd3
  } eprom_mode_e;

  // Content pattern written into the store during reset.
  function automatic logic [31:0] fill_word(input int unsigned idx,
                                            input int unsigned mul,
                                            input int unsigned add);
    return 32'(idx * mul + add);
  endfunction

  function automatic eprom_mode_e decode_mode(input logic ce_low,
                                              input logic oe_low,
                                              input logic hv);
    if (!ce_low)     return MODE_STANDBY;
    else if (!oe_low) return MODE_OUTDIS;
    else if (hv)     return MODE_IDENT;
    else             return MODE_ARRAY;
  endfunction

endpackage

// File: rtl/eprom_latency_ctr.sv
module eprom_latency_ctr #(
  parameter int unsigned LIMIT    = 4,
  parameter bit          RST_DONE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= RST_DONE ? LIM : '0;
    else if (restart)     cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done); // R7

endmodule

// File: rtl/eprom_store.sv
module eprom_store #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned PAT_MUL = 37,
  parameter int unsigned PAT_ADD = 90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  import eprom_emu_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= DW'(fill_word(i, PAT_MUL, PAT_ADD));
      end
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STORE_AW = 8,
  parameter int unsigned T_ADDR   = 4,
  parameter int unsigned T_CE     = 4,
  parameter int unsigned T_OE     = 2,
  parameter int unsigned T_FLOAT  = 3,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'h41,
  parameter int unsigned PAT_MUL  = 37,
  parameter int unsigned PAT_ADD  = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              hv_sig,
  output logic [DATA_W-1:0] q,
  output logic              q_oe,
  output logic              q_valid
);
  import eprom_emu_pkg::*;

  localparam int unsigned NPATH = 3;
  localparam int unsigned LIMS [NPATH] = '{T_ADDR, T_CE, T_OE};

  logic [ADDR_W-1:0] a_prev;
  logic              ce_prev, oe_prev, hv_prev;
  logic              addr_chg, ce_fall, oe_fall, en;
  logic [NPATH-1:0]  path_restart, path_done;
  logic              fl_done;
  logic [DATA_W-1:0] arr_data, sel_data;
  eprom_mode_e       mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev  <= '0;
      ce_prev <= 1'b1;
      oe_prev <= 1'b1;
      hv_prev <= 1'b0;
    end else begin
      a_prev  <= addr;
      ce_prev <= ce_n;
      oe_prev <= oe_n;
      hv_prev <= hv_sig;
    end
  end

  assign addr_chg = (addr != a_prev) || (hv_sig != hv_prev);
  assign ce_fall  = ce_prev && !ce_n;
  assign oe_fall  = oe_prev && !oe_n;
  assign path_restart = {oe_fall, ce_fall, addr_chg};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    eprom_latency_ctr #(.LIMIT(LIMS[p]), .RST_DONE(1'b0)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .restart(path_restart[p]), .done(path_done[p]));
  end

  assign mode = decode_mode(!ce_prev, !oe_prev, hv_prev);
  assign en   = (mode == MODE_ARRAY) || (mode == MODE_IDENT);

  eprom_latency_ctr #(.LIMIT(T_FLOAT), .RST_DONE(1'b1)) u_float (
    .clk(clk), .rst_n(rst_n), .restart(en), .done(fl_done));

  eprom_store #(.AW(STORE_AW), .DW(DATA_W), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(a_prev[STORE_AW-1:0]), .rd_data(arr_data));

  always_comb begin
    if (mode == MODE_IDENT) sel_data = a_prev[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
    else                    sel_data = arr_data;
  end

  assign q_valid = en && (&path_done);
  assign q_oe    = en || !fl_done;
  assign q       = q_valid ? sel_data : '0;

  AST_VALID_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> q_oe); // R2
  AST_ADDR_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> !q_valid); // R7
  AST_OE_FALL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    oe_fall |=> !q_valid); // R9
  AST_CE_FALL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> !q_valid); // R8
  AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (q_oe && !q_valid)); // R10
  AST_IDENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && hv_prev) |-> (q == DATA_W'(MFR_CODE) || q == DATA_W'(DEV_CODE))); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> (q == '0)); // R11

endmodule

// File: tb/test_eprom_emu.sv
module test_eprom_emu;
  localparam int T_ADDR = 4, T_CE = 4, T_OE = 2, T_FLOAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, hv_sig = 1'b0;
  logic [7:0]  q;
  logic        q_oe, q_valid;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eprom_emu i_eprom_emu (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .hv_sig(hv_sig), .q(q), .q_oe(q_oe), .q_valid(q_valid));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic o, input logic h, input logic [18:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; hv_sig = h; addr = a;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int arr_exp(input int idx);
    return (idx * 37 + 'h5A) & 'hFF;
  endfunction

  initial begin
    step(3);
    chk("R1 q_oe", q_oe, 0); chk("R1 q_valid", q_valid, 0); chk("R1 q", q, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R1 q_oe after", q_oe, 0); chk("R1 valid after", q_valid, 0);

    // R8 chip-enable delay, address and output enable settled
    drive(1, 0, 0, 19'h00010); step(8);
    chk("R3 standby oe low", q_oe, 0);
    drive(0, 0, 0, 19'h00010); step(T_CE);
    chk("R8 early valid", q_valid, 0); chk("R8 early drive", q_oe, 1); chk("R11 q zero", q, 0);
    step(1);
    chk("R8 valid", q_valid, 1); chk("R6 data", q, arr_exp('h10));

    // R10/R4 float after output enable rises
    drive(0, 1, 0, 19'h00010); step(1);
    chk("R10 drive held", q_oe, 1); chk("R10 invalid", q_valid, 0); chk("R11 q", q, 0);
    step(T_FLOAT - 1); chk("R10 last drive", q_oe, 1);
    step(1); chk("R4 outdis hiz", q_oe, 0);

    // R9 output-enable delay
    drive(0, 0, 0, 19'h00010); step(T_OE);
    chk("R9 early", q_valid, 0);
    step(1); chk("R9 valid", q_valid, 1); chk("R2 drive", q_oe, 1);

    // R9 simultaneous addr + oe: longest (T_ADDR) governs
    drive(0, 1, 0, 19'h00010); step(T_FLOAT + 1);
    drive(0, 0, 0, 19'h00022); step(T_ADDR);
    chk("R9 combined early", q_valid, 0);
    step(1); chk("R9 combined valid", q_valid, 1); chk("R6 combined data", q, arr_exp('h22));

    // R10/R3 float after chip enable rises, oe still low
    drive(1, 0, 0, 19'h00022); step(T_FLOAT);
    chk("R10 ce float held", q_oe, 1); chk("R10 ce invalid", q_valid, 0);
    step(1); chk("R3 standby hiz", q_oe, 0);
    step(5); chk("R3 standby stays", q_oe, 0); chk("R2 no valid standby", q_valid, 0);

    // R6/R7 exhaustive index sweep with mirrored upper bits
    drive(0, 0, 0, 19'h0); step(T_CE + 1);
    for (int i = 0; i < 256; i++) begin
      logic [10:0] up;
      up = 11'((i * 733) ^ 11'h5A5);
      drive(0, 0, 0, {up, 8'(i)});
      step(1); chk("R7 zero hold", q_valid, 0);
      step(T_ADDR - 1); chk("R7 early", q_valid, 0);
      step(1); chk("R7 valid", q_valid, 1); chk("R6 sweep", q, arr_exp(i));
    end

    // R5 identifier read
    for (int k = 0; k < 8; k++) begin
      logic [18:0] a;
      a = 19'((k * 40503) & 19'h7FFFE) | 19'(k & 1);
      drive(0, 0, 1, a); step(T_ADDR);
      chk("R7 ident early", q_valid, 0);
      step(1);
      chk("R5 ident valid", q_valid, 1);
      chk("R5 ident code", q, (k & 1) ? 'h41 : 'h20);
    end

    // R5 flag with ce high gives nothing
    drive(1, 0, 1, 19'h1); step(T_FLOAT + 2);
    chk("R5 ident standby hiz", q_oe, 0); chk("R11 q standby", q, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule